// File: doc/BRIEF.md
# Receive Frame Record Buffer

This block holds received frames in a circular store of 32-bit words until a host reads them. Each frame becomes one record of variable length. The record has four header words followed by enough words to hold the payload. A frame source writes the header and payload words. The block works out the record length from the payload byte count and the frame kind, and writes it into the low bits of the first stored word. A reader can use that field to find where each record ends.

A record becomes visible to the reader only once its last word is in the store. A frame that does not fit in the free space is discarded as a whole, and a sticky overrun flag is raised. The host pops words one at a time. It can see the frame count, the free word count, both pointers, the empty and full flags and the store size. The host has two commands: one empties the store, the other clears the overrun flag.

Top module: `rx_frame_buf`

## Requirements
- R1: One cycle after `cmd_flush`, the buffer is empty and not full. The frame count and both pointers are zero, and the free count equals DEPTH. Any frame still being written is abandoned.
- R2: Whenever `st_empty` is high, `st_free` equals DEPTH. `st_size` always reads DEPTH.
- R3: A frame with a payload of B bytes takes 4 + ceil(B/4) words. The low 5 bits of its first stored word hold the record word count, which is the word total minus one.
- R4: A classic-format remote frame (`wr_remote`=1, `wr_fd`=0) takes exactly 4 words whatever its byte count. A frame with zero payload bytes also takes 4 words.
- R5: The frame count rises by one in the cycle after the last word of an accepted frame is written.
- R6: At each store, the free count falls by the record's word total, so free words plus stored words always equal DEPTH.
- R7: A frame whose word total exceeds the free count at its first word sets `st_ovr` one cycle later. The flag stays set through later successful frames.
- R8: One cycle after `cmd_clr_ovr`, `st_ovr` reads 0.
- R9: An overflowing frame is dropped whole. The write pointer, free count and frame count stay unchanged, its later words are ignored, and frames stored afterwards read back intact.
- R10: While a frame is still being written, the write pointer and frame count do not move. A pop during that time sees no part of the frame.
- R11: A pop is answered on `rd_data` in the next cycle, in write order. Each pop advances the read pointer by one. Popping a record's last word lowers the frame count by one and returns that record's words to the free count.
- R12: A pop while empty gives `rd_data` = 0 in the next cycle and leaves the read pointer unchanged.
- R13: Both pointers wrap modulo DEPTH (a power of two). `st_full` is high exactly when the free count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_flush | input | 1 | Empty the buffer (one-cycle pulse) |
| cmd_clr_ovr | input | 1 | Clear the overrun flag (one-cycle pulse) |
| wr_valid | input | 1 | A frame word is presented |
| wr_sof | input | 1 | The presented word is the first word of a frame |
| wr_data | input | 32 | Frame word |
| wr_bytes | input | 7 | Payload byte count, 0 to 64, sampled with `wr_sof` |
| wr_remote | input | 1 | Remote-request frame, sampled with `wr_sof` |
| wr_fd | input | 1 | Flexible-data-rate format, sampled with `wr_sof` |
| rd_pop | input | 1 | Pop one word |
| rd_data | output | 32 | Popped word, valid the cycle after the pop |
| st_empty | output | 1 | No complete frame stored |
| st_full | output | 1 | Free count is zero |
| st_ovr | output | 1 | Sticky overrun flag |
| st_frames | output | AW+1 | Stored frame count |
| st_free | output | AW+1 | Free word count |
| st_wptr | output | AW | Write pointer |
| st_rptr | output | AW | Read pointer |
| st_size | output | AW+1 | Buffer size in words (DEPTH) |

## Verification
Frames are written with several length patterns: a payload that is a whole number of words, a payload with a partial last word, zero bytes, a classic remote frame that carries a byte count, and the 64-byte maximum. These patterns separate a correct ceiling calculation from an off-by-one in the record length or a wrongly ignored remote flag. A run of frames that wraps both pointers and fills the store to exactly zero free words shows the wrap and full behaviour. Overflowing frames sent just before and after that point show that a dropped frame leaves no trace in the read-back data. A pause in the middle of a frame, with a pop during it, confirms that partial records stay hidden. A flush in the middle of traffic, followed by a fresh frame, confirms a clean restart from address zero.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int WORD_W = 32;
  localparam int RWC_W  = 5;  // record word count field width
  localparam int BYTE_W = 7;  // payload byte count width
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rxb_rec_size.sv
module rxb_rec_size #(
  parameter int MAX_BYTES = 64
) (
  input  logic [rxb_pkg::BYTE_W-1:0] bytes,
  input  logic                       remote,
  input  logic                       fd,
  output logic [rxb_pkg::RWC_W-1:0]  rwcnt
);
  localparam int HDR_WORDS = 4;

  int nb;
  int words;

  always_comb begin
    nb = (int'(bytes) > MAX_BYTES) ? MAX_BYTES : int'(bytes);
    if (remote && !fd) words = HDR_WORDS;
    else               words = HDR_WORDS + (nb + 3) / 4;
    rwcnt = rxb_pkg::RWC_W'(words - 1);
  end
endmodule

// File: rtl/rxb_ram.sv
module rxb_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxb_rd_track.sv
module rxb_rd_track #(
  parameter int CW = 7,
  localparam int RW = rxb_pkg::RWC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          pop,
  input  logic [RW-1:0] q_len,     // length field of the word last read
  output logic          rd_last,
  output logic [CW-1:0] rec_words
);
  logic [RW-1:0] idx_q;
  logic [RW-1:0] len_q;
  logic          hdr_pend_q;
  logic [RW-1:0] len_eff;

  // The header length arrives one cycle after the first pop; records are
  // at least four words long, so it is known before the last pop.
  assign len_eff   = hdr_pend_q ? q_len : len_q;
  assign rd_last   = pop && (idx_q != '0) && (idx_q == len_eff);
  assign rec_words = CW'(len_eff) + CW'(1);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      idx_q      <= '0;
      len_q      <= '0;
      hdr_pend_q <= 1'b0;
    end else begin
      hdr_pend_q <= pop && (idx_q == '0);
      if (hdr_pend_q) len_q <= q_len;
      if (pop) idx_q <= rd_last ? '0 : idx_q + RW'(1);
    end
  end
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf #(
  parameter int DEPTH     = 64,
  parameter int MAX_BYTES = 64,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_flush,
  input  logic        cmd_clr_ovr,
  input  logic        wr_valid,
  input  logic        wr_sof,
  input  logic [31:0] wr_data,
  input  logic [6:0]  wr_bytes,
  input  logic        wr_remote,
  input  logic        wr_fd,
  input  logic        rd_pop,
  output logic [31:0] rd_data,
  output logic        st_empty,
  output logic        st_full,
  output logic        st_ovr,
  output logic [CW-1:0] st_frames,
  output logic [CW-1:0] st_free,
  output logic [AW-1:0] st_wptr,
  output logic [AW-1:0] st_rptr,
  output logic [CW-1:0] st_size
);
  import rxb_pkg::*;
  localparam int RW = RWC_W;

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] free_q, frames_q, free_n, frames_n;
  logic          full_q, empty_q, ovr_q;
  logic          wr_act_q;
  logic [RW-1:0] wr_off_q, wr_len_q;
  logic [RW-1:0] rec_rwcnt;
  logic          sof_ok, fits, ovf_evt, wr_first, wr_cont, commit;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  word_t         ram_wdata, ram_q;
  logic          do_pop, rd_last, rd_zero_q;
  logic [CW-1:0] rd_words;

  rxb_rec_size #(.MAX_BYTES(MAX_BYTES)) u_size (
    .bytes(wr_bytes), .remote(wr_remote), .fd(wr_fd), .rwcnt(rec_rwcnt)
  );

  // ---------------- write side ----------------
  assign sof_ok   = wr_valid && wr_sof;
  assign fits     = (CW'(rec_rwcnt) + CW'(1)) <= free_q;
  assign ovf_evt  = sof_ok && !fits && !cmd_flush;
  assign wr_first = sof_ok && fits && !cmd_flush;
  assign wr_cont  = wr_valid && !wr_sof && wr_act_q && !cmd_flush;
  assign commit   = wr_cont && (wr_off_q == wr_len_q);

  assign ram_we    = wr_first || wr_cont;
  assign ram_waddr = wr_first ? wptr_q : wptr_q + AW'(wr_off_q);
  assign ram_wdata = wr_first ? {wr_data[WORD_W-1:RW], rec_rwcnt} : wr_data;

  always_ff @(posedge clk) begin
    if (rst || cmd_flush) begin
      wr_act_q <= 1'b0;
      wr_off_q <= '0;
      wr_len_q <= '0;
    end else if (sof_ok) begin
      wr_act_q <= fits;
      wr_off_q <= RW'(1);
      wr_len_q <= rec_rwcnt;
    end else if (wr_cont) begin
      wr_off_q <= wr_off_q + RW'(1);
      if (commit) wr_act_q <= 1'b0;
    end
  end

  // ---------------- storage ----------------
  rxb_ram #(.DEPTH(DEPTH), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(do_pop), .raddr(rptr_q), .rdata(ram_q)
  );

  // ---------------- read side ----------------
  assign do_pop = rd_pop && !empty_q && !cmd_flush;

  rxb_rd_track #(.CW(CW)) u_track (
    .clk(clk), .rst(rst), .flush(cmd_flush), .pop(do_pop),
    .q_len(ram_q[RW-1:0]), .rd_last(rd_last), .rec_words(rd_words)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_zero_q <= 1'b1;
    else if (rd_pop) rd_zero_q <= !do_pop;
  end

  assign rd_data = rd_zero_q ? '0 : ram_q;

  // ---------------- occupancy ----------------
  always_comb begin
    free_n   = free_q;
    frames_n = frames_q;
    if (rd_last) begin
      free_n   = free_n + rd_words;
      frames_n = frames_n - CW'(1);
    end
    if (commit) begin
      free_n   = free_n - (CW'(wr_len_q) + CW'(1));
      frames_n = frames_n + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cmd_flush) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      free_q   <= CW'(DEPTH);
      frames_q <= '0;
      full_q   <= 1'b0;
      empty_q  <= 1'b1;
    end else begin
      if (commit) wptr_q <= wptr_q + AW'(wr_len_q) + AW'(1);
      if (do_pop) rptr_q <= rptr_q + AW'(1);
      free_q   <= free_n;
      frames_q <= frames_n;
      full_q   <= (free_n == '0);
      empty_q  <= (frames_n == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              ovr_q <= 1'b0;
    else if (ovf_evt)     ovr_q <= 1'b1;
    else if (cmd_clr_ovr) ovr_q <= 1'b0;
  end

  assign st_empty  = empty_q;
  assign st_full   = full_q;
  assign st_ovr    = ovr_q;
  assign st_frames = frames_q;
  assign st_free   = free_q;
  assign st_wptr   = wptr_q;
  assign st_rptr   = rptr_q;
  assign st_size   = CW'(DEPTH);

  // ---------------- assertions ----------------
  AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    cmd_flush |=> (st_empty && !st_full && st_frames == '0 && st_wptr == '0
                   && st_rptr == '0 && st_free == CW'(DEPTH))); // R1
  AST_EMPTY_ALL_FREE: assert property (@(posedge clk) disable iff (rst)
    st_empty |-> st_free == CW'(DEPTH)); // R2
  AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (rst)
    (commit && !rd_last) |=> st_frames == $past(st_frames) + CW'(1)); // R5
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
    st_free <= CW'(DEPTH)); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> st_ovr); // R7
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_ovr && !cmd_clr_ovr) |=> st_ovr); // R7
  AST_OVR_CLR: assert property (@(posedge clk) disable iff (rst)
    (cmd_clr_ovr && !ovf_evt) |=> !st_ovr); // R8
  AST_DROP_KEEP: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !rd_last) |=> ($stable(wptr_q) && $stable(frames_q) && $stable(free_q))); // R9
  AST_WPTR_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (!commit && !cmd_flush) |=> $stable(wptr_q)); // R10
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && st_empty) |=> (rd_data == '0 && $stable(st_rptr))); // R12
endmodule

// File: tb/rx_frame_buf_tb.sv
module rx_frame_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_flush = 1'b0, cmd_clr_ovr = 1'b0;
  logic wr_valid = 1'b0, wr_sof = 1'b0, wr_remote = 1'b0, wr_fd = 1'b0;
  logic [31:0] wr_data = '0;
  logic [6:0]  wr_bytes = '0;
  logic rd_pop = 1'b0;
  logic [31:0] rd_data;
  logic st_empty, st_full, st_ovr;
  logic [CW-1:0] st_frames, st_free, st_size;
  logic [AW-1:0] st_wptr, st_rptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_buf #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .cmd_flush(cmd_flush), .cmd_clr_ovr(cmd_clr_ovr),
    .wr_valid(wr_valid), .wr_sof(wr_sof), .wr_data(wr_data), .wr_bytes(wr_bytes),
    .wr_remote(wr_remote), .wr_fd(wr_fd), .rd_pop(rd_pop), .rd_data(rd_data),
    .st_empty(st_empty), .st_full(st_full), .st_ovr(st_ovr), .st_frames(st_frames),
    .st_free(st_free), .st_wptr(st_wptr), .st_rptr(st_rptr), .st_size(st_size)
  );

  int total = 0;
  int bad = 0;

  // bench model
  int mfree = DEPTH, mframes = 0, mwptr = 0, mrptr = 0;
  bit movr = 0;
  logic [31:0] mq[$];     // stored words of committed frames
  int          mlen[$];   // record lengths
  logic [31:0] exp_q[$];  // expected pop results
  logic        pop_d = 1'b0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each pop answer with the scoreboard
  always @(posedge clk) pop_d <= rd_pop;
  always @(negedge clk) begin
    if (!rst && pop_d) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R11: actual=%h expected=<none>", rd_data);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL R11/R12/R3: actual=%h expected=%h", rd_data, e);
        end
      end
    end
  end

  function automatic logic [31:0] wpat(int tag, int k);
    return {8'(tag), 8'h5A, 8'(k), 8'hC3};
  endfunction

  function automatic int rec_len(int bytes, bit remote, bit fd);
    return (remote && !fd) ? 4 : 4 + (bytes + 3) / 4;
  endfunction

  function automatic logic [31:0] stored(int tag, int k, int words);
    logic [31:0] w;
    w = wpat(tag, k);
    if (k == 0) w[4:0] = 5'(words - 1);
    return w;
  endfunction

  task automatic check_state(string req);
    chk({req, " frames"}, int'(st_frames), mframes);
    chk({req, " free"},   int'(st_free),   mfree);
    chk({req, " wptr"},   int'(st_wptr),   mwptr);
    chk({req, " rptr"},   int'(st_rptr),   mrptr);
    chk({req, " empty"},  int'(st_empty),  int'(mframes == 0));
    chk({req, " full"},   int'(st_full),   int'(mfree == 0));
    chk({req, " ovr"},    int'(st_ovr),    int'(movr));
  endtask

  task automatic drive_word(int tag, int k, int bytes, bit remote, bit fd);
    wr_valid  = 1'b1;
    wr_sof    = (k == 0);
    wr_data   = wpat(tag, k);
    wr_bytes  = 7'(bytes);
    wr_remote = remote;
    wr_fd     = fd;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_sof   = 1'b0;
  endtask

  task automatic model_store(int tag, int words, int fit);
    if (fit != 0) begin
      for (int k = 0; k < words; k++) mq.push_back(stored(tag, k, words));
      mlen.push_back(words);
      mframes++;
      mfree -= words;
      mwptr = (mwptr + words) % DEPTH;
    end else begin
      movr = 1;
    end
  endtask

  task automatic send_frame(int tag, int bytes, bit remote, bit fd, string req);
    int words;
    int fit;
    words = rec_len(bytes, remote, fd);
    fit = (words <= mfree) ? 1 : 0;
    for (int k = 0; k < words; k++) drive_word(tag, k, bytes, remote, fd);
    model_store(tag, words, fit);
    check_state(req);
  endtask

  task automatic drain_frames(int nf, string req);
    for (int f = 0; f < nf; f++) begin
      int len;
      len = mlen.pop_front();
      for (int k = 0; k < len; k++) begin
        exp_q.push_back(mq.pop_front());
        rd_pop = 1'b1;
        @(negedge clk);
        mrptr = (mrptr + 1) % DEPTH;
      end
      rd_pop = 1'b0;
      mframes--;
      mfree += len;
    end
    @(negedge clk);
    check_state(req);
  endtask

  task automatic empty_pop(string req);
    exp_q.push_back(32'h0);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
    chk({req, " rptr"}, int'(st_rptr), mrptr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R1, R2)
    check_state("R1 reset");
    chk("R2 size", int'(st_size), DEPTH);

    // R3/R5/R6: whole-word payload
    send_frame(1, 8, 0, 0, "R3 R5 R6 8B");
    // R4: classic remote with byte count
    send_frame(2, 8, 1, 0, "R4 remote");
    // R4: zero payload, flexible format
    send_frame(3, 0, 0, 1, "R4 zero");
    // R3: partial last word
    send_frame(4, 5, 0, 0, "R3 5B");
    // R3: maximum payload
    send_frame(5, 64, 0, 1, "R3 64B");
    // R11: read everything back
    drain_frames(5, "R11 drain");
    // R12: pop while empty
    empty_pop("R12");

    // R10: staging hides a partial frame
    for (int k = 0; k < 3; k++) drive_word(6, k, 7, 0, 0);
    chk("R10 frames", int'(st_frames), mframes);
    chk("R10 wptr", int'(st_wptr), mwptr);
    empty_pop("R10");
    for (int k = 3; k < 6; k++) drive_word(6, k, 7, 0, 0);
    model_store(6, 6, 1);
    check_state("R10 commit");

    // R13 wrap, fill, R7/R9 overflow
    send_frame(7, 64, 0, 1, "R13 wrap");
    send_frame(8, 64, 0, 1, "R13 fill");
    send_frame(9, 12, 0, 0, "R6 12B");
    send_frame(10, 8, 0, 0, "R6 8B");
    send_frame(11, 64, 0, 1, "R7 R9 overflow");
    send_frame(12, 4, 0, 0, "R13 full R7 sticky");
    send_frame(13, 3, 1, 0, "R9 overflow at full");
    drain_frames(6, "R13 R9 drain");

    // R8: clear overrun
    cmd_clr_ovr = 1'b1;
    @(negedge clk);
    cmd_clr_ovr = 1'b0;
    movr = 0;
    chk("R8 ovr", int'(st_ovr), 0);

    // R1: flush with content
    send_frame(14, 3, 0, 0, "R3 3B");
    send_frame(15, 0, 0, 0, "R4 zero classic");
    cmd_flush = 1'b1;
    @(negedge clk);
    cmd_flush = 1'b0;
    mq.delete();
    mlen.delete();
    mframes = 0; mfree = DEPTH; mwptr = 0; mrptr = 0;
    check_state("R1 flush");
    send_frame(16, 16, 0, 0, "R1 after flush");
    drain_frames(1, "R1 R11 readback");

    repeat (2) @(negedge clk);
    chk("R11 scoreboard empty", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule